// File: doc/BRIEF.md
# Protected System Clock Selector

This block produces the system clock from one of four oscillator sources and divides it by a power of two. Two fields set the source and the ratio: a source code and a divider code. Both sit in one selection register. That register accepts writes only while a 16-bit key register holds the unlock value. A separate, unprotected sleep-control register holds one bit per source. While the sleep request input is high, those bits decide which oscillators get a run enable and which are told to stop.

Source changes never cut a clock phase short. A small controller in the always-on configuration clock domain runs three named states. ST_ENGAGE waits until the requested source's gate reports that it is open. From there it moves to ST_RUN. ST_RUN accepts selection writes. A write that names a different source moves it to ST_RELEASE. ST_RELEASE closes every gate and waits until all of them report closed. It then returns to ST_ENGAGE. Each source has its own gate cell. The cell carries the open request over a two-flop synchronizer clocked by that source. It changes its enable only on the source's falling edge, and it returns the enable state to the controller over another two-flop synchronizer. After reset the controller starts in ST_ENGAGE with the internal oscillator as target.

Top module: `sysclk_selector`

## Requirements
- R1: After reset, `cur_src` is 0 (internal oscillator), every bit of `run_en` is 1, the selection register is locked, and `sys_clk` runs at the internal oscillator's period with no division.
- R2: Source codes are 0 internal, 1 low-speed, 2 high-speed, 3 external. The code is written to bits [1:0] of the selection register at address 1. Once the switch completes, `cur_src` shows the code and `sys_clk` has that source's period.
- R3: Divider code k is written to bits [3:2] of the selection register. It makes the `sys_clk` period 2^k times the selected source period, for ratios 1, 2, 4 and 8.
- R4: A write to the selection register takes effect only while the key register at address 0 holds 0x0096. Writing any other key value locks the register again. A locked write changes neither `cur_src` nor the `sys_clk` period.
- R5: A selection write that names a source whose `src_ready` bit is 0 is dropped whole. Neither the source nor the divider changes.
- R6: A selection write that arrives while a switch is in progress (controller not in ST_RUN) is dropped whole.
- R7: At most one source gate is open at any time. During source switches with divider code 0, `sys_clk` shows no high or low phase shorter than the shortest half-period among the sources involved.
- R8: While `sleep_req` is 1, `run_en[i]` equals the inverse of sleep-control bit i, and a bit of 1 stops that source even when it is the selected one. While `sleep_req` is 0, all `run_en` bits are 1.
- R9: The sleep-control register (address 2, bit i for source i) is writable while the selection register is locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Always-on configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_clk | input | 4 | Oscillator clocks, bit i is source code i |
| src_ready | input | 4 | Oscillator i is running and stable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 key, 1 selection, 2 sleep control |
| wr_data | input | 16 | Write data |
| sleep_req | input | 1 | Deep-sleep request |
| sys_clk | output | 1 | Selected and divided system clock |
| run_en | output | 4 | Per-source keep-running enable |
| cur_src | output | 2 | Source currently driving the system clock |

## Verification
The main function is tried with a table of source and divider pairs. The table covers every source and every divider code, and the bench measures the output period after each pair. A wrong source and a wrong ratio show up as different period values. Writes made while locked, with a wrong key, to a source that is not ready, and back to back during a switch each leave both the current source and the period unchanged. This separates the protection check, the ready check and the busy check from one another. A sequence of switches with the divider at 1 is watched for short phases. The sleep-control patterns 0101, 1111 and 0000 are applied with the sleep request both high and low, which tells per-source gating apart from gating of all sources together.

// File: rtl/sysclk_pkg.sv
`timescale 1ns/1ps
package sysclk_pkg;
    localparam logic [15:0] UNLOCK_KEY = 16'h0096;
    localparam logic [1:0]  ADDR_KEY   = 2'd0;
    localparam logic [1:0]  ADDR_SEL   = 2'd1;
    localparam logic [1:0]  ADDR_SLP   = 2'd2;

    typedef enum logic [1:0] {
        ST_ENGAGE  = 2'd0,
        ST_RUN     = 2'd1,
        ST_RELEASE = 2'd2
    } sw_state_e;
endpackage

// File: rtl/clk_gate_cell.sv
`timescale 1ns/1ps
module clk_gate_cell #(
    parameter int SYNC_STAGES = 2
) (
    input  logic src_clk,
    input  logic cfg_clk,
    input  logic rst_n,
    input  logic req,
    output logic gclk,
    output logic ack
);
    logic [SYNC_STAGES-1:0] req_sync;
    logic [SYNC_STAGES-1:0] ack_sync;
    logic                   en_q;

    // open request carried into the source domain
    always_ff @(posedge src_clk or negedge rst_n) begin
        if (!rst_n) req_sync <= '0;
        else        req_sync <= {req_sync[SYNC_STAGES-2:0], req};
    end

    // enable moves only while the source clock is low
    always_ff @(negedge src_clk or negedge rst_n) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= req_sync[SYNC_STAGES-1];
    end

    assign gclk = src_clk & en_q;

    // gate state reported back to the control domain
    always_ff @(posedge cfg_clk or negedge rst_n) begin
        if (!rst_n) ack_sync <= '0;
        else        ack_sync <= {ack_sync[SYNC_STAGES-2:0], en_q};
    end

    assign ack = ack_sync[SYNC_STAGES-1];
endmodule

// File: rtl/clk_divider.sv
`timescale 1ns/1ps
module clk_divider #(
    parameter int DIV_W       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             mux_clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_code,
    output logic             clk_out
);
    localparam int N_CODES = 1 << DIV_W;
    localparam int CNT_W   = N_CODES - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [DIV_W-1:0] code_sync [SYNC_STAGES];
    logic [DIV_W-1:0] code_act;

    always_ff @(posedge mux_clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            code_act <= '0;
            for (int s = 0; s < SYNC_STAGES; s++) code_sync[s] <= '0;
        end else begin
            cnt_q        <= cnt_q + 1'b1;
            code_sync[0] <= div_code;
            for (int s = 1; s < SYNC_STAGES; s++) code_sync[s] <= code_sync[s-1];
            // a new ratio takes over only as the counter wraps
            if (&cnt_q) code_act <= code_sync[SYNC_STAGES-1];
        end
    end

    always_comb begin
        clk_out = mux_clk;
        for (int k = 1; k < N_CODES; k++) begin
            if (code_act == DIV_W'(k)) clk_out = cnt_q[k-1];
        end
    end
endmodule

// File: rtl/sysclk_ctrl.sv
`timescale 1ns/1ps
module sysclk_ctrl
    import sysclk_pkg::*;
#(
    parameter int N_SRC  = 4,
    parameter int SRC_W  = 2,
    parameter int DIV_W  = 2,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 2
) (
    input  logic              cfg_clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [N_SRC-1:0]  src_ready,
    input  logic [N_SRC-1:0]  ack,
    output logic [N_SRC-1:0]  req,
    output logic [DIV_W-1:0]  div_code,
    output logic [SRC_W-1:0]  cur_src,
    output logic [N_SRC-1:0]  slp_bits
);
    sw_state_e         state_q, state_d;
    logic [15:0]       key_q;
    logic [SRC_W-1:0]  tgt_q, cur_q, new_src;
    logic [DIV_W-1:0]  div_q, new_div;
    logic [N_SRC-1:0]  slp_q;
    logic              unlocked, sel_hit, new_ready, accept, tgt_open;

    assign unlocked  = (key_q == UNLOCK_KEY);
    assign sel_hit   = wr_en && (wr_addr == ADDR_W'(ADDR_SEL));
    assign new_src   = wr_data[SRC_W-1:0];
    assign new_div   = wr_data[SRC_W +: DIV_W];
    assign new_ready = (int'(new_src) < N_SRC) && src_ready[new_src];
    assign accept    = sel_hit && unlocked && (state_q == ST_RUN) && new_ready;
    assign tgt_open  = ack[tgt_q];

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ENGAGE:  if (tgt_open) state_d = ST_RUN;
            ST_RUN:     if (accept && (new_src != tgt_q)) state_d = ST_RELEASE;
            ST_RELEASE: if (ack == '0) state_d = ST_ENGAGE;
            default:    state_d = ST_ENGAGE;
        endcase
    end

    // state register
    always_ff @(posedge cfg_clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_ENGAGE;
        else        state_q <= state_d;
    end

    // configuration registers
    always_ff @(posedge cfg_clk or negedge rst_n) begin
        if (!rst_n) begin
            key_q <= '0;
            slp_q <= '0;
            tgt_q <= '0;
            div_q <= '0;
            cur_q <= '0;
        end else begin
            if (wr_en && (wr_addr == ADDR_W'(ADDR_KEY))) key_q <= wr_data[15:0];
            if (wr_en && (wr_addr == ADDR_W'(ADDR_SLP))) slp_q <= wr_data[N_SRC-1:0];
            if (accept) begin
                tgt_q <= new_src;
                div_q <= new_div;
            end
            if ((state_q == ST_ENGAGE) && tgt_open) cur_q <= tgt_q;
        end
    end

    // outputs
    always_comb begin
        req = '0;
        if (state_q != ST_RELEASE) req[tgt_q] = 1'b1;
        div_code = div_q;
        cur_src  = cur_q;
        slp_bits = slp_q;
    end

    // R7
    gate_onehot_chk: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        $onehot0(ack));

    // R4
    locked_sel_chk: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        (sel_hit && !unlocked) |=> ($stable(tgt_q) && $stable(div_q)));

    // R5
    not_ready_chk: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        (sel_hit && !new_ready) |=> ($stable(tgt_q) && $stable(div_q)));

    // R6
    busy_write_chk: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        (state_q != ST_RUN) |=> $stable(div_q));

    // R2
    commit_chk: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        ((state_q == ST_ENGAGE) && tgt_open) |=> (cur_q == $past(tgt_q)));
endmodule

// File: rtl/sysclk_selector.sv
`timescale 1ns/1ps
module sysclk_selector #(
    parameter int N_SRC       = 4,
    parameter int DIV_W       = 2,
    parameter int DATA_W      = 16,
    parameter int ADDR_W      = 2,
    parameter int SYNC_STAGES = 2,
    localparam int SRC_W      = $clog2(N_SRC)
) (
    input  logic              cfg_clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_clk,
    input  logic [N_SRC-1:0]  src_ready,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              sleep_req,
    output logic              sys_clk,
    output logic [N_SRC-1:0]  run_en,
    output logic [SRC_W-1:0]  cur_src
);
    logic [N_SRC-1:0] req, ack, gclk, slp_bits;
    logic [DIV_W-1:0] div_code;
    logic             mux_clk;

    sysclk_ctrl #(
        .N_SRC(N_SRC), .SRC_W(SRC_W), .DIV_W(DIV_W),
        .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) u_ctrl (
        .cfg_clk(cfg_clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .src_ready(src_ready), .ack(ack), .req(req),
        .div_code(div_code), .cur_src(cur_src), .slp_bits(slp_bits)
    );

    for (genvar i = 0; i < N_SRC; i++) begin : g_gate
        clk_gate_cell #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
            .src_clk(src_clk[i]), .cfg_clk(cfg_clk), .rst_n(rst_n),
            .req(req[i]), .gclk(gclk[i]), .ack(ack[i])
        );
    end

    assign mux_clk = |gclk;

    clk_divider #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_div (
        .mux_clk(mux_clk), .rst_n(rst_n), .div_code(div_code), .clk_out(sys_clk)
    );

    always_comb begin
        run_en = ~(slp_bits & {N_SRC{sleep_req}});
    end

    // R8
    wake_run_chk: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        !sleep_req |-> (run_en == '1));
endmodule

// File: tb/sysclk_selector_bench.sv
`timescale 1ns/1ps
module sysclk_selector_bench;
    localparam int CFG_PERIOD = 10;
    localparam int PER [4] = '{14, 40, 6, 22};
    // {src[1:0], div[1:0]}
    localparam logic [3:0] VEC [6] = '{4'b1000, 4'b0101, 4'b1110, 4'b0011, 4'b1010, 4'b0000};

    logic        cfg_clk = 0, rst_n = 0;
    logic        s0 = 0, s1 = 0, s2 = 0, s3 = 0;
    logic [3:0]  src_clk, src_ready = 4'hF, run_en;
    logic        wr_en = 0, sleep_req = 0, sys_clk;
    logic [1:0]  wr_addr = 0, cur_src;
    logic [15:0] wr_data = 0;
    int          checks = 0, failures = 0;
    bit          done = 0, watch = 0;
    realtime     last_edge = 0, min_pulse = 1.0e9;

    assign src_clk = {s3, s2, s1, s0};

    initial forever #(CFG_PERIOD/2) cfg_clk = ~cfg_clk;
    initial forever #(PER[0]/2) s0 = ~s0;
    initial forever #(PER[1]/2) s1 = ~s1;
    initial forever #(PER[2]/2) s2 = ~s2;
    initial forever #(PER[3]/2) s3 = ~s3;

    sysclk_selector u_sysclk_selector (
        .cfg_clk(cfg_clk), .rst_n(rst_n), .src_clk(src_clk), .src_ready(src_ready),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .sleep_req(sleep_req),
        .sys_clk(sys_clk), .run_en(run_en), .cur_src(cur_src)
    );

    always @(sys_clk) begin
        if (watch && (($realtime - last_edge) < min_pulse)) min_pulse = $realtime - last_edge;
        last_edge = $realtime;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge cfg_clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge cfg_clk);
        wr_en = 0;
    endtask

    task automatic settle();
        repeat (400) @(negedge cfg_clk);
    endtask

    task automatic period(output int p);
        longint t0;
        @(posedge sys_clk); t0 = longint'($time);
        @(posedge sys_clk); p = int'(longint'($time) - t0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(CFG_PERIOD * 150000);
        failures++;
        $display("FAIL R1 watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        int p;
        repeat (3) @(negedge cfg_clk);
        rst_n = 1;
        @(negedge cfg_clk);
        // R1 reset state
        check(cur_src == 2'd0, "R1 cur_src", cur_src, 0);
        check(run_en == 4'hF, "R1 run_en", run_en, 15);
        settle();
        period(p);
        check(p == PER[0], "R1 period", p, PER[0]);

        // R2 / R3 table of source and divider pairs
        wr(2'd0, 16'h0096);
        for (int i = 0; i < 6; i++) begin
            logic [1:0] s, d;
            s = VEC[i][3:2]; d = VEC[i][1:0];
            wr(2'd1, {12'd0, d, s});
            settle();
            check(cur_src == s, "R2 cur_src", cur_src, s);
            period(p);
            check(p == (PER[s] << d), "R3 period", p, PER[s] << d);
        end

        // R4 wrong key locks
        wr(2'd0, 16'h0095);
        wr(2'd1, {12'd0, 2'd1, 2'd2});
        settle();
        check(cur_src == 2'd0, "R4 locked cur_src", cur_src, 0);
        period(p);
        check(p == PER[0], "R4 locked period", p, PER[0]);

        // R5 source not ready
        wr(2'd0, 16'h0096);
        src_ready = 4'b0111;
        wr(2'd1, {12'd0, 2'd1, 2'd3});
        settle();
        check(cur_src == 2'd0, "R5 cur_src", cur_src, 0);
        period(p);
        check(p == PER[0], "R5 period", p, PER[0]);
        src_ready = 4'hF;

        // R6 write during a switch
        wr(2'd1, {12'd0, 2'd0, 2'd1});
        wr(2'd1, {12'd0, 2'd2, 2'd3});
        settle();
        check(cur_src == 2'd1, "R6 cur_src", cur_src, 1);
        period(p);
        check(p == PER[1], "R6 period", p, PER[1]);

        // R7 switch chain with divider code 0
        min_pulse = 1.0e9;
        watch = 1;
        wr(2'd1, 16'd2); settle();
        wr(2'd1, 16'd3); settle();
        wr(2'd1, 16'd0); settle();
        watch = 0;
        check(int'(min_pulse * 1000) >= 3000, "R7 min pulse ps", int'(min_pulse * 1000), 3000);
        check(cur_src == 2'd0, "R7 cur_src", cur_src, 0);

        // R9 sleep bits writable while locked; R8 gating
        wr(2'd0, 16'h0000);
        wr(2'd2, 16'h0005);
        check(run_en == 4'hF, "R8 awake run_en", run_en, 15);
        sleep_req = 1; #1;
        check(run_en == 4'b1010, "R9 R8 sleep 0101", run_en, 10);
        wr(2'd2, 16'h000F); #1;
        check(run_en == 4'b0000, "R8 sleep 1111", run_en, 0);
        wr(2'd2, 16'h0000); #1;
        check(run_en == 4'hF, "R8 sleep 0000", run_en, 15);
        wr(2'd2, 16'h000F);
        sleep_req = 0; #1;
        check(run_en == 4'hF, "R8 wake 1111", run_en, 15);

        finish_run();
    end
endmodule